// File: doc/BRIEF.md
# JTAG Test Access Port with Flag-Mapped Instruction Register

This block is a boundary-scan style test access port controller. It runs the standard sixteen-state TAP state machine from TMS, sampled on the rising edge of TCK. It holds a 24-bit instruction register. Every bit of that register is an independent control flag toward the chip, except for a three-bit data-register select field. The flags sit in a shadow register that changes only when the controller passes through Update-IR. Shifting a new instruction therefore never disturbs the chip, whatever passes through the shift stage.

Behind the instruction register are four data-register targets: a one-bit bypass stage, a 32-bit identification register, a generic user data register with a parallel holding stage, and an external shift port. Scan chains or test engines elsewhere on the chip attach to that port. All shift stages are plain shift registers, filled from TDI toward TDO with the least significant bit leaving first. An overlong shift simply leaves the last bits received in the register, in its upper positions. This lets a host that always shifts whole bytes still load the intended value. TDO is launched on the falling edge of TCK. An output-enable pin marks the Shift-IR and Shift-DR states, and TDO idles high outside them. The serial pins have no handshake of their own: TCK paces every transfer, and the external port follows the TCK-paced state.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low, ctrl_flags_o is all zeros, tdo_oe is 0, tdo is 1, and the select field is 3'b001 (identification register).
- R2: In Capture-DR with the select field IR[2:0] = 3'b001, the 32-bit identification register loads the constant 32'h4B1DE0A7 (LSB is 1). Shift-DR then presents it on TDO least significant bit first.
- R3: In Capture-IR, the instruction shift stage loads 24'hA5A5A5 (two LSBs are binary 01). Shift-IR presents it on TDO least significant bit first.
- R4: ctrl_flags_o equals IR[23:3] of the shadow register. It does not change during Shift-IR, Exit1-IR, Pause-IR, Exit2-IR or on entry to Update-IR. It takes the shifted value on the TCK rising edge that leaves Update-IR.
- R5: A select field of 3'b000 or 3'b1xx selects the one-bit bypass register. It captures 0 in Capture-DR, and in Shift-DR TDO repeats TDI one shift later.
- R6: A select field of 3'b010 selects the user register (16 bits by default). Capture-DR loads the holding value, and Update-DR copies the shift stage into the holding value shown on user_data_o. After an overlong shift, the last 16 bits received are kept.
- R7: Shifting more than 24 bits into the instruction register leaves the last 24 bits received, and only those bits reach the shadow at Update-IR.
- R8: Five consecutive TCK rising edges with TMS high bring the controller to Test-Logic-Reset from any state. The shadow returns to its default value on the edge that enters that state: select 3'b001, all flags zero.
- R9: Driving trst_n low resets the state machine, shadow, TDO and tdo_oe at once, without a TCK edge.
- R10: TDO and tdo_oe change only on the falling edge of TCK. tdo_oe is 1 exactly while the state is Shift-IR or Shift-DR, and tdo is 1 whenever tdo_oe is 0.
- R11: A select field of 3'b011 routes the data path to the external port. ext_sel_o is high, and ext_capture_o, ext_shift_o and ext_update_o are high in Capture-DR, Shift-DR and Update-DR respectively. TDO then carries ext_tdo_i, sampled on the falling edge of TCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low controller reset |
| tms | input | 1 | Mode select, sampled on TCK rise |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on TCK fall |
| tdo_oe | output | 1 | High while TDO carries shift data |
| ctrl_flags_o | output | 21 | Instruction flags IR[23:3] from the shadow |
| user_data_o | output | 16 | Holding value of the user register |
| ext_sel_o | output | 1 | External data register selected |
| ext_capture_o | output | 1 | External capture strobe |
| ext_shift_o | output | 1 | External shift enable |
| ext_update_o | output | 1 | External update strobe |
| ext_tdo_i | input | 1 | Serial return from the external register |

## Verification
The hardest situation to reach from the pins is a flag change caught between shifting and Update-IR. The stimulus parks the controller in Pause-IR after a full instruction has been shifted, and again on entry to Update-IR. In both places it confirms that the flags still hold the old value, then shows the new value one edge later. Asynchronous reset is applied in the middle of a Shift-DR, after the falling edge has already raised tdo_oe. The five-edge TMS escape starts from Shift-DR with non-zero flags, so the flags clear at exactly the fifth edge and not before. A bench model of an eight-bit external register answers the external port, so that the TDO stream checks data passing through it.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDCODE, DR_USER, DR_EXT
  } dr_sel_e;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_CODE_ID   = 3'b001;
  localparam logic [SEL_W-1:0] SEL_CODE_USER = 3'b010;
  localparam logic [SEL_W-1:0] SEL_CODE_EXT  = 3'b011;
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm import jtag_tap_pkg::*; (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_o,
  output tap_state_e next_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign next_o  = state_d;

  // checker: run length of TMS high
  logic [2:0] tms_run_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 tms_run_q <= '0;
    else if (!tms)               tms_run_q <= '0;
    else if (tms_run_q != 3'd7)  tms_run_q <= tms_run_q + 3'd1;
  end

  AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run_q >= 3'd5) |-> (state_q == ST_TLR)); // R8
endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir import jtag_tap_pkg::*; #(
  parameter int          IR_W       = 24,
  parameter logic [IR_W-1:0] IR_CAPTURE = 24'hA5A5A5,
  parameter logic [IR_W-1:0] IR_DEFAULT = 24'h000001
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state_i,
  input  tap_state_e      next_i,
  output logic            ir_lsb_o,
  output logic [IR_W-1:0] shadow_o
);
  logic [IR_W-1:0] shift_q, shadow_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                    shift_q <= '0;
    else if (state_i == ST_CAP_IR)  shift_q <= IR_CAPTURE;
    else if (state_i == ST_SHF_IR)  shift_q <= {tdi, shift_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                    shadow_q <= IR_DEFAULT;
    else if (next_i == ST_TLR)      shadow_q <= IR_DEFAULT;
    else if (state_i == ST_UPD_IR)  shadow_q <= shift_q;
  end

  assign ir_lsb_o = shift_q[0];
  assign shadow_o = shadow_q;

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    (state_i == ST_CAP_IR) |=> (shift_q == IR_CAPTURE)); // R3
  AST_SHADOW_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
    (state_i != ST_UPD_IR && next_i != ST_TLR) |=> $stable(shadow_q)); // R4
endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr import jtag_tap_pkg::*; #(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] IDCODE = 32'h4B1DE0A7,
  parameter int              USER_W = 16
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        state_i,
  input  dr_sel_e           sel_i,
  input  logic              ext_tdo_i,
  output logic              dr_lsb_o,
  output logic [USER_W-1:0] user_data_o
);
  logic              byp_q;
  logic [ID_W-1:0]   id_q;
  logic [USER_W-1:0] usr_q, usr_hold_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q      <= 1'b0;
      id_q       <= '0;
      usr_q      <= '0;
      usr_hold_q <= '0;
    end else begin
      unique case (sel_i)
        DR_BYPASS: begin
          if (state_i == ST_CAP_DR)      byp_q <= 1'b0;
          else if (state_i == ST_SHF_DR) byp_q <= tdi;
        end
        DR_IDCODE: begin
          if (state_i == ST_CAP_DR)      id_q <= IDCODE;
          else if (state_i == ST_SHF_DR) id_q <= {tdi, id_q[ID_W-1:1]};
        end
        DR_USER: begin
          if (state_i == ST_CAP_DR)      usr_q <= usr_hold_q;
          else if (state_i == ST_SHF_DR) usr_q <= {tdi, usr_q[USER_W-1:1]};
          else if (state_i == ST_UPD_DR) usr_hold_q <= usr_q;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      DR_BYPASS: dr_lsb_o = byp_q;
      DR_IDCODE: dr_lsb_o = id_q[0];
      DR_USER:   dr_lsb_o = usr_q[0];
      default:   dr_lsb_o = ext_tdo_i;
    endcase
  end

  assign user_data_o = usr_hold_q;

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (state_i == ST_CAP_DR && sel_i == DR_BYPASS) |=> (byp_q == 1'b0)); // R5
  AST_ID_LSB_ONE: assert property (@(posedge tck) disable iff (!trst_n)
    (state_i == ST_CAP_DR && sel_i == DR_IDCODE) |=> (id_q[0] == 1'b1)); // R2
  AST_USER_HOLD_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
    !(state_i == ST_UPD_DR && sel_i == DR_USER) |=> $stable(usr_hold_q)); // R6
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl import jtag_tap_pkg::*; #(
  parameter int                IR_W       = 24,
  parameter logic [IR_W-1:0]   IR_CAPTURE = 24'hA5A5A5,
  parameter logic [IR_W-1:0]   IR_DEFAULT = 24'h000001,
  parameter int                ID_W       = 32,
  parameter logic [ID_W-1:0]   IDCODE     = 32'h4B1DE0A7,
  parameter int                USER_W     = 16
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [IR_W-4:0]   ctrl_flags_o,
  output logic [USER_W-1:0] user_data_o,
  output logic              ext_sel_o,
  output logic              ext_capture_o,
  output logic              ext_shift_o,
  output logic              ext_update_o,
  input  logic              ext_tdo_i
);
  localparam int FLAG_W = IR_W - SEL_W;

  tap_state_e      state, next_state;
  logic            ir_lsb, dr_lsb;
  logic [IR_W-1:0] shadow;
  dr_sel_e         dr_sel;

  jtag_tap_fsm fsm_i (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .state_o(state), .next_o(next_state)
  );

  jtag_tap_ir #(.IR_W(IR_W), .IR_CAPTURE(IR_CAPTURE), .IR_DEFAULT(IR_DEFAULT)) ir_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .state_i(state), .next_i(next_state),
    .ir_lsb_o(ir_lsb), .shadow_o(shadow)
  );

  always_comb begin
    unique case (shadow[SEL_W-1:0])
      SEL_CODE_ID:   dr_sel = DR_IDCODE;
      SEL_CODE_USER: dr_sel = DR_USER;
      SEL_CODE_EXT:  dr_sel = DR_EXT;
      default:       dr_sel = DR_BYPASS;
    endcase
  end

  jtag_tap_dr #(.ID_W(ID_W), .IDCODE(IDCODE), .USER_W(USER_W)) dr_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .state_i(state), .sel_i(dr_sel), .ext_tdo_i(ext_tdo_i),
    .dr_lsb_o(dr_lsb), .user_data_o(user_data_o)
  );

  logic tdo_q, oe_q;
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_SHF_IR: begin tdo_q <= ir_lsb; oe_q <= 1'b1; end
        ST_SHF_DR: begin tdo_q <= dr_lsb; oe_q <= 1'b1; end
        default:   begin tdo_q <= 1'b1;   oe_q <= 1'b0; end
      endcase
    end
  end

  assign tdo           = tdo_q;
  assign tdo_oe        = oe_q;
  assign ctrl_flags_o  = shadow[IR_W-1:SEL_W];
  assign ext_sel_o     = (dr_sel == DR_EXT);
  assign ext_capture_o = ext_sel_o && (state == ST_CAP_DR);
  assign ext_shift_o   = ext_sel_o && (state == ST_SHF_DR);
  assign ext_update_o  = ext_sel_o && (state == ST_UPD_DR);

  initial begin
    AST_FLAG_WIDTH: assert (FLAG_W == $bits(ctrl_flags_o)); // R4
  end

  AST_OE_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR)); // R10
  AST_IDLE_TDO_HIGH: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> tdo); // R10
endmodule

// File: tb/jtag_tap_ctrl_tb_top.sv
module jtag_tap_ctrl_tb_top;
  localparam logic [31:0] ID_VAL  = 32'h4B1DE0A7;
  localparam logic [23:0] IR_CAP  = 24'hA5A5A5;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, ext_sel_o, ext_capture_o, ext_shift_o, ext_update_o, ext_tdo_i;
  logic [20:0] ctrl_flags_o;
  logic [15:0] user_data_o;

  int checks = 0, failures = 0;
  logic exp_q[$];
  string tag_q[$];
  logic [7:0] ext_q = 8'h00;
  int ext_shifts = 0, ext_updates = 0;
  logic [63:0] fin;

  always #5 tck = ~tck;

  jtag_tap_ctrl dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .ctrl_flags_o(ctrl_flags_o), .user_data_o(user_data_o),
    .ext_sel_o(ext_sel_o), .ext_capture_o(ext_capture_o), .ext_shift_o(ext_shift_o),
    .ext_update_o(ext_update_o), .ext_tdo_i(ext_tdo_i)
  );

  // external eight-bit register model
  assign ext_tdo_i = ext_q[0];
  always @(posedge tck) begin
    if (ext_capture_o) ext_q <= 8'h3C;
    else if (ext_shift_o) begin
      ext_q <= {tdi, ext_q[7:1]};
      ext_shifts <= ext_shifts + 1;
    end
    if (ext_update_o) ext_updates <= ext_updates + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge tck) begin
    if (trst_n && tdo_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected shift bit", {63'd0, tdo}, 64'd0);
      else begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(tdo === e, t, {63'd0, tdo}, {63'd0, e});
      end
    end
  end

  task automatic model_push(input int n, input logic [63:0] din, input logic [63:0] cap,
                            input int w, input string tag, output logic [63:0] res);
    logic [63:0] q;
    q = cap;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(q[0]);
      tag_q.push_back(tag);
      q = (q >> 1) | ({63'd0, din[i]} << (w - 1));
    end
    res = q & ((64'd1 << w) - 64'd1);
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, input logic [63:0] cap,
                          input int w, input string tag, output logic [63:0] res);
    model_push(n, din, cap, w, tag, res);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_ir(input int n, input logic [63:0] din, input string tag);
    logic [63:0] r;
    model_push(n, din, {40'd0, IR_CAP}, 24, tag, r);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #200000;
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #22;
    chk(ctrl_flags_o == 21'd0, "R1 flags in reset", {43'd0, ctrl_flags_o}, 64'd0);
    chk(tdo_oe == 1'b0, "R1 oe in reset", {63'd0, tdo_oe}, 64'd0);
    chk(tdo == 1'b1, "R1 tdo in reset", {63'd0, tdo}, 64'd1);
    trst_n = 1'b1;
    @(posedge tck); #1;
    tick(0, 0);

    // R1 default select is the identification register, R2 capture and LSB-first shift
    shift_dr(32, 64'd0, {32'd0, ID_VAL}, 32, "R2 idcode bit", fin);

    // R3 capture pattern, load user select
    shift_ir(24, 64'h000002, "R3 ir capture bit");
    chk(ctrl_flags_o == 21'd0, "R3 flags after user select", {43'd0, ctrl_flags_o}, 64'd0);

    // R4 flags held until Update-IR is left
    begin
      logic [23:0] v;
      v = {21'h155555, 3'b010};
      model_push(24, {40'd0, v}, {40'd0, IR_CAP}, 24, "R4 ir capture bit", fin);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 24; i++) tick(i == 23, v[i]);
      chk(ctrl_flags_o == 21'd0, "R4 flags in Exit1-IR", {43'd0, ctrl_flags_o}, 64'd0);
      tick(0, 0); tick(0, 0);
      chk(ctrl_flags_o == 21'd0, "R4 flags in Pause-IR", {43'd0, ctrl_flags_o}, 64'd0);
      tick(1, 0); tick(1, 0);
      chk(ctrl_flags_o == 21'd0, "R4 flags entering Update-IR", {43'd0, ctrl_flags_o}, 64'd0);
      tick(0, 0);
      chk(ctrl_flags_o == 21'h155555, "R4 flags after Update-IR", {43'd0, ctrl_flags_o}, 64'h155555);
    end

    // R6 user register: overlong shift, update, capture of hold
    shift_dr(24, 64'h9C_5A3E, 64'd0, 16, "R6 user bit", fin);
    chk(user_data_o == 16'h9C5A, "R6 overlong user keeps last bits", {48'd0, user_data_o}, 64'h9C5A);
    shift_dr(16, 64'h1234, 64'h9C5A, 16, "R6 user capture bit", fin);
    chk(user_data_o == 16'h1234, "R6 user update", {48'd0, user_data_o}, 64'h1234);

    // R5 bypass
    shift_ir(24, 64'hFFFFFF, "R5 ir capture bit");
    chk(ctrl_flags_o == 21'h1FFFFF, "R5 flags all ones", {43'd0, ctrl_flags_o}, 64'h1FFFFF);
    shift_dr(8, 64'hB4, 64'd0, 1, "R5 bypass bit", fin);

    // R10 falling-edge launch, R9 async reset mid-shift
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk(tdo_oe == 1'b0, "R10 oe before falling edge", {63'd0, tdo_oe}, 64'd0);
    #5;
    chk(tdo_oe == 1'b1, "R10 oe after falling edge", {63'd0, tdo_oe}, 64'd1);
    chk(tdo == 1'b0, "R10 bypass capture on tdo", {63'd0, tdo}, 64'd0);
    trst_n = 1'b0; tms = 1'b1;
    #1;
    chk(ctrl_flags_o == 21'd0, "R9 flags cleared async", {43'd0, ctrl_flags_o}, 64'd0);
    chk(tdo_oe == 1'b0, "R9 oe cleared async", {63'd0, tdo_oe}, 64'd0);
    chk(tdo == 1'b1, "R9 tdo idle async", {63'd0, tdo}, 64'd1);
    @(posedge tck); #1;
    trst_n = 1'b1;
    tick(0, 0);
    shift_dr(32, 64'd0, {32'd0, ID_VAL}, 32, "R9 idcode after reset bit", fin);

    // R7 overlong instruction shift
    shift_ir(32, 64'h0505_017E, "R7 ir capture bit");
    chk(ctrl_flags_o == 21'h0A0A0, "R7 flags from last 24 bits", {43'd0, ctrl_flags_o}, 64'h0A0A0);
    shift_dr(32, 64'hFFFF_FFFF, {32'd0, ID_VAL}, 32, "R7 idcode bit", fin);

    // R11 external port
    shift_ir(24, 64'h000003, "R11 ir capture bit");
    chk(ext_sel_o == 1'b1, "R11 ext selected", {63'd0, ext_sel_o}, 64'd1);
    shift_dr(12, 64'hA5C, 64'h3C, 8, "R11 ext bit", fin);
    chk(ext_shifts == 12, "R11 ext shift count", ext_shifts, 64'd12);
    chk(ext_updates == 1, "R11 ext update count", ext_updates, 64'd1);
    chk(ext_q == fin[7:0], "R11 ext register content", {56'd0, ext_q}, fin);

    // R8 five TMS-high edges from Shift-DR
    shift_ir(24, 64'hFFFFF9, "R8 ir capture bit");
    chk(ctrl_flags_o == 21'h1FFFFF, "R8 flags set", {43'd0, ctrl_flags_o}, 64'h1FFFFF);
    exp_q.push_back(1'b1); tag_q.push_back("R8 idcode bit");
    tick(1, 0); tick(0, 0); tick(0, 0);
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    chk(ctrl_flags_o == 21'h1FFFFF, "R8 flags after four edges", {43'd0, ctrl_flags_o}, 64'h1FFFFF);
    tick(1, 0);
    chk(ctrl_flags_o == 21'd0, "R8 flags after five edges", {43'd0, ctrl_flags_o}, 64'd0);
    tick(1, 0); tick(0, 0);
    shift_dr(32, 64'd0, {32'd0, ID_VAL}, 32, "R8 default idcode bit", fin);

    #20;
    chk(exp_q.size() == 0, "R10 all expected bits seen", exp_q.size(), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule